// File: doc/BRIEF.md
# Single-Slice PWM Generator with Pin-Driven Advance Modes

This block produces two pulse-width-modulated outputs from one 16-bit up-counter. The counter climbs from zero to a programmable wrap value and then starts again at zero. Each output compares the counter against its own 16-bit threshold and can be inverted. A fractional clock divider sets how often the counter steps.

Pin B can also act as an input instead of an output. In that case it either gates the divider, so the counter only runs while the pin is high, or it supplies rising or falling edges that the counter counts one by one. The input passes through a synchronizer before use. All settings are written through one simple write port. The live counter value is always visible on an output bus. A one-cycle pulse marks each wrap and serves as the interrupt source.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter reads 0 and `out_a`, `out_b` and `wrap_pulse` are low. `pin_b_oe` is high. The divider is 1.0 (integer 1, fraction 0) and the wrap value is 0xFFFF, so once enabled in mode 0 the counter steps on every clock.
- R2: In mode 0, with divider integer I and fraction F, the counter steps floor(16·N/(16·I+F)) times in N enabled clocks, counted from a reset divider phase. I = 0 is treated as 256.
- R3: When the counter holds the active wrap value and steps again, it becomes 0. `wrap_pulse` is then high for exactly the one cycle in which the counter reads 0.
- R4: Each output is registered. In each cycle it equals (counter value of the previous cycle < that channel's threshold), XOR that channel's invert bit. A threshold of 0 with the invert bit clear therefore holds the output low.
- R5: In mode 1 the divider runs only in cycles where the synchronized pin B is high. While the pin is low the counter does not move.
- R6: In mode 2 (rising edges) and mode 3 (falling edges), the divider is ignored. Each edge of pin B, after a two-flop synchronizer, advances the counter exactly once.
- R7: While the enable bit is 0 the counter keeps its value.
- R8: A write to register 2 loads the counter with bits 15:0 of the write data. `ctr_value` shows the new value on the next cycle.
- R9: Writes to the threshold register (3) or the wrap register (4) made while enabled take effect only at the next wrap. Writes made while disabled take effect on the following clock.
- R10: `pin_b_oe` is high in mode 0 and low in modes 1, 2 and 3.
- R11: Register map, by write address:
  - 0 is control: bit 0 enable, bit 2 invert A, bit 3 invert B, bits 5:4 mode.
  - 1 is the divider: bits 3:0 fraction, bits 11:4 integer.
  - 2 is the counter.
  - 3 holds the thresholds: A in bits 15:0, B in bits 31:16.
  - 4 is the wrap value, bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| pin_b_in | input | 1 | Pin B input, asynchronous |
| ctr_value | output | 16 | Current counter value |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| pin_b_oe | output | 1 | High when pin B is driven as an output |
| wrap_pulse | output | 1 | One-cycle pulse on counter wrap |

## Verification
Most internal faults surface on `ctr_value` within a single clock. A divider accumulator that is off shows up as a wrong step count at the end of a run. A lost or doubled edge shows as a counter that is short or long by one after a burst of pin pulses. A threshold or wrap value that updates too early corrupts the output levels and the peak counter value inside the period where the write happened. An inverted or mistimed output compare is caught by checking, on every cycle, each output against the counter value seen one cycle earlier.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

  typedef enum logic [1:0] {
    ADV_FREE  = 2'd0,
    ADV_GATED = 2'd1,
    ADV_RISE  = 2'd2,
    ADV_FALL  = 2'd3
  } adv_mode_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] REG_DIV   = 3'd1;
  localparam logic [REG_AW-1:0] REG_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] REG_CMP   = 3'd3;
  localparam logic [REG_AW-1:0] REG_WRAP  = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INV_LSB  = 2;
  localparam int CTRL_MODE_LSB = 4;

endpackage

// File: rtl/pwm_slice_regs.sv
module pwm_slice_regs
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  parameter int NCH    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [REG_AW-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         period_end,
  output logic                         enable,
  output logic [NCH-1:0]               inv,
  output adv_mode_e                    mode,
  output logic [INT_W-1:0]             div_int,
  output logic [FRAC_W-1:0]            div_frac,
  output logic [NCH-1:0][CNT_W-1:0]    cmp_act,
  output logic [CNT_W-1:0]             wrap_act,
  output logic                         cnt_load,
  output logic [CNT_W-1:0]             cnt_load_val
);

  localparam logic [INT_W-1:0] INT_RESET = INT_W'(1);

  logic [NCH-1:0][CNT_W-1:0] cmp_stg;
  logic [CNT_W-1:0]          wrap_stg;

  // Software-visible staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      enable   <= 1'b0;
      inv      <= '0;
      mode     <= ADV_FREE;
      div_int  <= INT_RESET;
      div_frac <= '0;
      cmp_stg  <= '0;
      wrap_stg <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          enable <= wr_data[CTRL_EN_BIT];
          inv    <= wr_data[CTRL_INV_LSB +: NCH];
          mode   <= adv_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
        end
        REG_DIV: begin
          div_frac <= wr_data[FRAC_W-1:0];
          div_int  <= wr_data[FRAC_W +: INT_W];
        end
        REG_CMP: begin
          for (int c = 0; c < NCH; c++) begin
            cmp_stg[c] <= wr_data[c*CNT_W +: CNT_W];
          end
        end
        REG_WRAP: wrap_stg <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // Active copies: follow staging while idle, otherwise only at period end
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act  <= '0;
      wrap_act <= '1;
    end else if (!enable || period_end) begin
      cmp_act  <= cmp_stg;
      wrap_act <= wrap_stg;
    end
  end

  assign cnt_load     = wr_en && (wr_addr == REG_COUNT);
  assign cnt_load_val = wr_data[CNT_W-1:0];

endmodule

// File: rtl/pwm_slice_fracdiv.sv
module pwm_slice_fracdiv #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  localparam int DIV_W = INT_W + FRAC_W + 1;
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] period;

  // Integer zero selects the longest period (2**INT_W)
  always_comb begin
    if (div_int == '0) period = ACC_W'({1'b1, {INT_W{1'b0}}, div_frac});
    else               period = ACC_W'({1'b0, div_int, div_frac});
    sum  = acc + STEP;
    tick = run && (sum >= period);
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (run) acc <= tick ? (sum - period) : sum;
  end

endmodule

// File: rtl/pwm_slice_pinsync.sv
module pwm_slice_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sr;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[0] <= 1'b0;
        else     sr[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= 1'b0;
        else     sr[g] <= sr[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sr[STAGES-1];
  end

  assign level = sr[STAGES-1];
  assign rise  = sr[STAGES-1] & ~prev;
  assign fall  = ~sr[STAGES-1] & prev;

endmodule

// File: rtl/pwm_slice_counter.sv
module pwm_slice_counter #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      advance,
  input  logic                      cnt_load,
  input  logic [CNT_W-1:0]          cnt_load_val,
  input  logic [CNT_W-1:0]          wrap_act,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_act,
  input  logic [NCH-1:0]            inv,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0]            ch_out,
  output logic                      wrap_pulse,
  output logic                      period_end
);

  assign period_end = advance && !cnt_load && (cnt == wrap_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= period_end;
      if (cnt_load)     cnt <= cnt_load_val;
      else if (advance) cnt <= period_end ? '0 : cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) ch_out[c] <= 1'b0;
      else     ch_out[c] <= (cnt < cmp_act[c]) ^ inv[c];
    end
  end

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pin_b_in,
  output logic [CNT_W-1:0]  ctr_value,
  output logic              out_a,
  output logic              out_b,
  output logic              pin_b_oe,
  output logic              wrap_pulse
);

  localparam int NCH = 2;

  logic                      en_w;
  logic [NCH-1:0]            inv_w;
  adv_mode_e                 mode_w;
  logic [INT_W-1:0]          div_int_w;
  logic [FRAC_W-1:0]         div_frac_w;
  logic [NCH-1:0][CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0]          wrap_w;
  logic                      load_w;
  logic [CNT_W-1:0]          load_val_w;
  logic                      period_end_w;
  logic                      b_level, b_rise, b_fall;
  logic                      div_run, div_tick, edge_step, advance;
  logic [NCH-1:0]            ch_w;

  pwm_slice_regs #(
    .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .NCH(NCH)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_end(period_end_w), .enable(en_w), .inv(inv_w), .mode(mode_w),
    .div_int(div_int_w), .div_frac(div_frac_w), .cmp_act(cmp_w),
    .wrap_act(wrap_w), .cnt_load(load_w), .cnt_load_val(load_val_w)
  );

  pwm_slice_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_b_in),
    .level(b_level), .rise(b_rise), .fall(b_fall)
  );

  always_comb begin
    div_run   = 1'b0;
    edge_step = 1'b0;
    case (mode_w)
      ADV_FREE:  div_run   = en_w;
      ADV_GATED: div_run   = en_w & b_level;
      ADV_RISE:  edge_step = en_w & b_rise;
      ADV_FALL:  edge_step = en_w & b_fall;
      default: ;
    endcase
  end

  pwm_slice_fracdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .run(div_run),
    .div_int(div_int_w), .div_frac(div_frac_w), .tick(div_tick)
  );

  assign advance = div_tick | edge_step;

  pwm_slice_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
    .clk(clk), .rst(rst), .advance(advance), .cnt_load(load_w),
    .cnt_load_val(load_val_w), .wrap_act(wrap_w), .cmp_act(cmp_w),
    .inv(inv_w), .cnt(ctr_value), .ch_out(ch_w),
    .wrap_pulse(wrap_pulse), .period_end(period_end_w)
  );

  assign out_a    = ch_w[0];
  assign out_b    = ch_w[1];
  assign pin_b_oe = (mode_w == ADV_FREE);

endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] ctr_value,
  input logic             wrap_pulse,
  input logic             out_a,
  input logic             en,
  input logic             load,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cmp_a,
  input logic             inv_a
);

  // R3: the wrap strobe coincides with a zero counter
  assert_wrap_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (ctr_value == '0));

  // R3: a wrap strobe needs a step taken while enabled
  assert_wrap_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> $past(en));

  // R7: disabled and not written, the counter stays put
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(ctr_value));

  // R6: in the edge modes the counter moves by at most one per cycle
  assert_edge_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (en && mode[1] && !load) |=>
      ((ctr_value == $past(ctr_value)) ||
       (ctr_value == CNT_W'($past(ctr_value) + 1'b1)) ||
       (ctr_value == '0)));

  // R4: a zero threshold with no inversion keeps output A low
  assert_zero_cmp_low_R4: assert property (@(posedge clk) disable iff (rst)
    ((cmp_a == '0) && !inv_a) |=> !out_a);

endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctr_value(ctr_value), .wrap_pulse(wrap_pulse),
  .out_a(out_a), .en(en_w), .load(load_w), .mode(mode_w),
  .cmp_a(cmp_w[0]), .inv_a(inv_w[0])
);

// File: tb/sim_pwm_slice.sv
`timescale 1ns/1ps
module sim_pwm_slice;
  import pwm_slice_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pin_b = 1'b0;
  logic [15:0] ctr_value;
  logic        out_a, out_b, pin_b_oe, wrap_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_slice u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_b_in(pin_b), .ctr_value(ctr_value), .out_a(out_a), .out_b(out_b),
    .pin_b_oe(pin_b_oe), .wrap_pulse(wrap_pulse)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        pin;
    logic [7:0]  dint;
    logic [3:0]  dfrac;
    logic [15:0] wrap;
    logic [15:0] ca;
    logic [15:0] cb;
    logic        ia;
    logic        ib;
    logic [15:0] n;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 8'd1, 4'd0, 16'd9,   16'd3, 16'd7,   1'b0, 1'b0, 16'd25},
    '{2'd0, 1'b0, 8'd2, 4'd8, 16'd4,   16'd2, 16'd4,   1'b1, 1'b0, 16'd30},
    '{2'd0, 1'b0, 8'd1, 4'd0, 16'd100, 16'd0, 16'd20,  1'b0, 1'b1, 16'd50},
    '{2'd1, 1'b1, 8'd3, 4'd0, 16'd7,   16'd4, 16'd200, 1'b0, 1'b0, 16'd40},
    '{2'd1, 1'b0, 8'd1, 4'd0, 16'd7,   16'd4, 16'd0,   1'b0, 1'b0, 16'd40},
    '{2'd0, 1'b0, 8'd0, 4'd0, 16'd1,   16'd1, 16'd2,   1'b0, 1'b0, 16'd600},
    '{2'd0, 1'b0, 8'd1, 4'd4, 16'd3,   16'd2, 16'd3,   1'b1, 1'b1, 16'd17}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_b();
    pin_b = 1'b1;
    repeat (3) @(negedge clk);
    pin_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk(ctr_value == 0, "R1 counter after reset", ctr_value, 0);
    chk({out_a, out_b, wrap_pulse} == 3'b000, "R1 outputs after reset", {out_a, out_b, wrap_pulse}, 0);
    chk(pin_b_oe == 1'b1, "R1/R10 pin B driven after reset", pin_b_oe, 1);

    // R1: default divider 1.0 and wrap 0xFFFF, counter steps every clock
    wr(REG_CTRL, 32'h1);
    repeat (9) @(negedge clk);
    chk(ctr_value == 9, "R1 default divider steps each clock", ctr_value, 9);
    wr(REG_CTRL, 32'h0);
    chk(ctr_value == 10, "R1 count on disable edge", ctr_value, 10);

    // R7: disabled counter holds
    repeat (20) @(negedge clk);
    chk(ctr_value == 10, "R7 hold while disabled", ctr_value, 10);

    // R8: counter load
    wr(REG_COUNT, 32'h0000_1234);
    chk(ctr_value == 16'h1234, "R8 counter load", ctr_value, 16'h1234);

    // Vector table: R2 R3 R4 R5 R11
    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      logic [15:0] prev;
      int nwrap, bad_a, bad_b, divv, adv, exp_ctr, exp_w;
      t = VECS[v];
      pin_b = t.pin;
      do_reset();
      wr(REG_DIV, {20'd0, t.dint, t.dfrac});
      wr(REG_WRAP, {16'd0, t.wrap});
      wr(REG_CMP, {t.cb, t.ca});
      wr(REG_CTRL, {26'd0, t.mode, t.ib, t.ia, 1'b0, 1'b1});
      prev = ctr_value;
      nwrap = 0; bad_a = 0; bad_b = 0;
      for (int i = 1; i <= int'(t.n); i++) begin
        if (i == int'(t.n)) begin
          wr_en = 1'b1; wr_addr = REG_CTRL;
          wr_data = {26'd0, t.mode, t.ib, t.ia, 2'b00};
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (wrap_pulse) nwrap++;
        if (out_a !== ((prev < t.ca) ^ t.ia)) bad_a++;
        if (out_b !== ((prev < t.cb) ^ t.ib)) bad_b++;
        prev = ctr_value;
      end
      divv = ((t.dint == 0) ? 256 : int'(t.dint)) * 16 + int'(t.dfrac);
      adv = ((t.mode == 2'd0) || (t.mode == 2'd1 && t.pin)) ? (16 * int'(t.n)) / divv : 0;
      exp_ctr = adv % (int'(t.wrap) + 1);
      exp_w = adv / (int'(t.wrap) + 1);
      chk(int'(ctr_value) == exp_ctr, $sformatf("R2/R5 vector %0d final count", v), ctr_value, exp_ctr);
      chk(nwrap == exp_w, $sformatf("R3 vector %0d wrap pulses", v), nwrap, exp_w);
      chk(bad_a == 0, $sformatf("R4 vector %0d output A mismatching cycles", v), bad_a, 0);
      chk(bad_b == 0, $sformatf("R4 vector %0d output B mismatching cycles", v), bad_b, 0);
    end

    // R6 / R10: edge counting, divider ignored
    pin_b = 1'b0;
    do_reset();
    wr(REG_CTRL, 32'h21);
    chk(pin_b_oe == 1'b0, "R10 pin B released in rise mode", pin_b_oe, 0);
    repeat (4) pulse_b();
    repeat (6) @(negedge clk);
    chk(ctr_value == 4, "R6 rising edges counted", ctr_value, 4);
    wr(REG_CTRL, 32'h31);
    repeat (3) pulse_b();
    repeat (6) @(negedge clk);
    chk(ctr_value == 7, "R6 falling edges counted", ctr_value, 7);

    // R9: deferred threshold and wrap updates while running
    begin
      logic [15:0] prev;
      int eff, bad, max1, max2, seen, zbad;
      do_reset();
      wr(REG_WRAP, 32'd9);
      wr(REG_CMP, 32'd5);
      wr(REG_CTRL, 32'h1);
      for (int k = 0; k < 50 && ctr_value != 16'd3; k++) @(negedge clk);
      prev = ctr_value;
      eff = 5; bad = 0; max1 = 0; max2 = 0; seen = 0; zbad = 0;
      for (int i = 0; i < 40; i++) begin
        if (i == 0) begin wr_en = 1'b1; wr_addr = REG_CMP; wr_data = 32'd2; end
        else if (i == 1) begin wr_en = 1'b1; wr_addr = REG_WRAP; wr_data = 32'd4; end
        else wr_en = 1'b0;
        @(negedge clk);
        if (out_a !== (int'(prev) < eff)) bad++;
        if (seen == 0) max1 = (int'(ctr_value) > max1) ? int'(ctr_value) : max1;
        else           max2 = (int'(ctr_value) > max2) ? int'(ctr_value) : max2;
        if (wrap_pulse) begin
          seen++;
          eff = 2;
          if (ctr_value != 0) zbad++;
        end
        prev = ctr_value;
      end
      wr_en = 1'b0;
      chk(max1 == 9, "R9 old wrap kept until period end", max1, 9);
      chk(max2 == 4, "R9 new wrap used after period end", max2, 4);
      chk(bad == 0, "R9 threshold switch at period end", bad, 0);
      chk(zbad == 0 && seen > 1, "R3 wrap pulse with zero count", zbad, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule